// File: doc/BRIEF.md
# SD Host DMA Channel Controller

This block sits between the register bus of an SD host and a word-wide memory port. Software writes a 64-bit start address as two 32-bit words. It also writes a block count, a block size in bytes, a direction and an address-step mode. It then writes the start bit in the control register. That bit clears itself. The channel then moves `(count * size) / 4` words between the card-side data handshake and memory. When the data has moved, it raises the done flag that belongs to the chosen direction.

The memory side is a ready/valid request port. A write request carries the word taken from the card. A read request takes its data from `mem_rdata` in the same cycle that `mem_rdy` is high. The card's data-line engine is not part of this block. It is modelled by a push port in each direction. If the extended-mode DMA enable is clear, a start does nothing and `pio_sel` tells the data path to use register-based transfer. If the start address is not 16-byte aligned, no data moves and the error flag for the selected direction is set.

Top module: `sdh_dma_ctrl`

## Requirements
- R1: After reset every register reads zero, no memory request is raised, and `pio_sel` is high.
- R2: Register map by `reg_sel`: 0 mode (bit 16 = 1 card-to-memory, 0 memory-to-card; bit 0 = 1 address steps by 4, 0 fixed), 1 control, 2 done status, 3 error status, 4 address low, 5 address high, 6 extended mode (bit 1 = DMA enable), 7 block count, 8 block size in bytes. Mode, extended mode, address, count and size read back what was written. `pio_sel` equals the inverse of the enable bit.
- R3: Control bit 0 starts a transfer and always reads back 0. A start while the enable bit is clear moves no data and sets no status.
- R4: One accepted start moves exactly `floor(count*size/4)` words, using count and size as they were sampled at the start write. After that there are no further memory requests.
- R5: Card-to-memory runs issue write requests (`mem_we`=1) that carry the `card_din` words in order. With stepping on, word i goes to start + 4*i. When the run ends, done bit 20 is set.
- R6: Memory-to-card runs issue read requests (`mem_we`=0), and each `mem_rdata` word is passed out on `card_dout` with `card_dout_vld` in the same cycle. When the run ends, done bit 16 is set.
- R7: With stepping off, every request of a run uses the start address.
- R8: A start address with any of bits [3:0] set moves no data. It sets error bit 17 (card-to-memory) or bit 16 (memory-to-card) and sets no done bit.
- R9: A write to a status register clears each bit written as 0 and keeps each bit written as 1. A write of zero clears the register.
- R10: Writes to the address registers are ignored while a transfer is active.
- R11: A start written while a transfer is active is ignored.
- R12: A start with zero length sets the done bit for its direction at once and moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register picked by `reg_sel` (combinational) |
| pio_sel | output | 1 | High when DMA is disabled and register-based transfer is used |
| mem_req_vld | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 64 | Byte address of the request |
| mem_wdata | output | 32 | Write data of the request |
| mem_rdy | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_rdy` |
| card_din | input | 32 | Word from the card side |
| card_din_vld | input | 1 | Card word available |
| card_din_pop | output | 1 | Card word consumed this cycle |
| card_dout | output | 32 | Word to the card side |
| card_dout_vld | output | 1 | `card_dout` valid this cycle |
| card_dout_rdy | input | 1 | Card side can take a word |

## Verification
Register writes take effect on the clock edge that samples the strobe. Status flags set by a completed, misaligned or zero-length start are therefore visible from the next falling edge. The bench drives inputs on the falling edge and reads status after a short settle delay at the following falling edge. Memory and card handshakes complete on the rising edge that follows the falling edge at which they are observed. The bench monitor sets `mem_rdy` and `card_dout_rdy`, waits for the outputs to settle, and records the beat that the next rising edge will commit. It advances the card word only after that edge. A sweep over count, size, direction and step mode compares each beat against addresses and data worked out by arithmetic.

// File: rtl/sdh_dma_pkg.sv
package sdh_dma_pkg;
  localparam logic [3:0] SEL_MODE    = 4'd0;
  localparam logic [3:0] SEL_CTRL    = 4'd1;
  localparam logic [3:0] SEL_DONE    = 4'd2;
  localparam logic [3:0] SEL_ERR     = 4'd3;
  localparam logic [3:0] SEL_ADDR_LO = 4'd4;
  localparam logic [3:0] SEL_ADDR_HI = 4'd5;
  localparam logic [3:0] SEL_XMODE   = 4'd6;
  localparam logic [3:0] SEL_BLKCNT  = 4'd7;
  localparam logic [3:0] SEL_BLKSIZE = 4'd8;

  localparam int BIT_DIR     = 16;
  localparam int BIT_INC     = 0;
  localparam int BIT_START   = 0;
  localparam int BIT_EN      = 1;
  localparam int BIT_RD_DONE = 20;
  localparam int BIT_WR_DONE = 16;
  localparam int BIT_RD_ERR  = 17;
  localparam int BIT_WR_ERR  = 16;

  function automatic logic [31:0] xfer_words(input logic [31:0] cnt,
                                             input logic [31:0] bsz,
                                             input int unsigned wb);
    logic [31:0] bytes;
    bytes = cnt * bsz;
    return bytes / 32'(wb);
  endfunction

  function automatic logic addr_aligned(input logic [63:0] a, input int unsigned lsb);
    logic [63:0] m;
    m = (64'd1 << lsb) - 64'd1;
    return (a & m) == 64'd0;
  endfunction
endpackage

// File: rtl/sdh_dma_regs.sv
module sdh_dma_regs
  import sdh_dma_pkg::*;
#(
  parameter int AW    = 64,
  parameter int CNT_W = 8,
  parameter int BSZ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       sel,
  input  logic [31:0]      wdata,
  input  logic             busy,
  input  logic             set_rd_done,
  input  logic             set_wr_done,
  input  logic             set_rd_err,
  input  logic             set_wr_err,
  output logic             mode_dir,
  output logic             mode_inc,
  output logic             dma_en,
  output logic [AW-1:0]    start_addr,
  output logic [CNT_W-1:0] blk_cnt,
  output logic [BSZ_W-1:0] blk_size,
  output logic [31:0]      rdata
);
  localparam int HI_W = AW - 32;

  logic [31:0]   addr_lo_q;
  logic [HI_W-1:0] addr_hi_q;
  logic rd_done_q, wr_done_q, rd_err_q, wr_err_q;

  logic wr_mode, wr_done_reg, wr_err_reg, wr_lo, wr_hi, wr_x, wr_cnt, wr_sz;
  assign wr_mode     = wr_en && sel == SEL_MODE;
  assign wr_done_reg = wr_en && sel == SEL_DONE;
  assign wr_err_reg  = wr_en && sel == SEL_ERR;
  assign wr_lo       = wr_en && sel == SEL_ADDR_LO && !busy;
  assign wr_hi       = wr_en && sel == SEL_ADDR_HI && !busy;
  assign wr_x        = wr_en && sel == SEL_XMODE;
  assign wr_cnt      = wr_en && sel == SEL_BLKCNT;
  assign wr_sz       = wr_en && sel == SEL_BLKSIZE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_dir  <= 1'b0;
      mode_inc  <= 1'b0;
      dma_en    <= 1'b0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      blk_cnt   <= '0;
      blk_size  <= '0;
      rd_done_q <= 1'b0;
      wr_done_q <= 1'b0;
      rd_err_q  <= 1'b0;
      wr_err_q  <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode_dir <= wdata[BIT_DIR];
        mode_inc <= wdata[BIT_INC];
      end
      if (wr_x)   dma_en    <= wdata[BIT_EN];
      if (wr_lo)  addr_lo_q <= wdata;
      if (wr_hi)  addr_hi_q <= wdata[HI_W-1:0];
      if (wr_cnt) blk_cnt   <= wdata[CNT_W-1:0];
      if (wr_sz)  blk_size  <= wdata[BSZ_W-1:0];
      rd_done_q <= (wr_done_reg ? (rd_done_q & wdata[BIT_RD_DONE]) : rd_done_q) | set_rd_done;
      wr_done_q <= (wr_done_reg ? (wr_done_q & wdata[BIT_WR_DONE]) : wr_done_q) | set_wr_done;
      rd_err_q  <= (wr_err_reg  ? (rd_err_q  & wdata[BIT_RD_ERR])  : rd_err_q)  | set_rd_err;
      wr_err_q  <= (wr_err_reg  ? (wr_err_q  & wdata[BIT_WR_ERR])  : wr_err_q)  | set_wr_err;
    end
  end

  assign start_addr = {addr_hi_q, addr_lo_q};

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_MODE: begin
        rdata[BIT_DIR] = mode_dir;
        rdata[BIT_INC] = mode_inc;
      end
      SEL_DONE: begin
        rdata[BIT_RD_DONE] = rd_done_q;
        rdata[BIT_WR_DONE] = wr_done_q;
      end
      SEL_ERR: begin
        rdata[BIT_RD_ERR] = rd_err_q;
        rdata[BIT_WR_ERR] = wr_err_q;
      end
      SEL_ADDR_LO: rdata = addr_lo_q;
      SEL_ADDR_HI: rdata = 32'(addr_hi_q);
      SEL_XMODE:   rdata[BIT_EN] = dma_en;
      SEL_BLKCNT:  rdata = 32'(blk_cnt);
      SEL_BLKSIZE: rdata = 32'(blk_size);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdh_dma_engine.sv
module sdh_dma_engine
  import sdh_dma_pkg::*;
#(
  parameter int AW          = 64,
  parameter int CNT_W       = 8,
  parameter int BSZ_W       = 12,
  parameter int WORD_BYTES  = 4,
  parameter int ALIGN_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             dma_en,
  input  logic             mode_dir,
  input  logic             mode_inc,
  input  logic [AW-1:0]    start_addr,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic [BSZ_W-1:0] blk_size,
  input  logic             card_din_vld,
  input  logic             card_dout_rdy,
  input  logic             mem_rdy,
  output logic             busy,
  output logic             dir_q,
  output logic             inc_q,
  output logic [AW-1:0]    cur_addr,
  output logic             req_vld,
  output logic             start_accept,
  output logic             misalign_hit,
  output logic             word_xfer,
  output logic             last_word,
  output logic             set_rd_done,
  output logic             set_wr_done,
  output logic             set_rd_err,
  output logic             set_wr_err
);
  localparam int REM_W     = CNT_W + BSZ_W;
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  logic [REM_W-1:0] remaining;
  logic [REM_W-1:0] len_words;
  logic             zero_len, launch;
  logic [63:0]      addr_ext;

  assign addr_ext     = 64'(start_addr);
  assign len_words    = REM_W'(xfer_words(32'(blk_cnt), 32'(blk_size), WORD_BYTES));
  assign start_accept = start_req && dma_en && !busy;
  assign misalign_hit = start_accept && !addr_aligned(addr_ext, ALIGN_LSB);
  assign zero_len     = start_accept && !misalign_hit && len_words == '0;
  assign launch       = start_accept && !misalign_hit && len_words != '0;

  assign req_vld   = busy && (dir_q ? card_din_vld : card_dout_rdy);
  assign word_xfer = req_vld && mem_rdy;
  assign last_word = word_xfer && remaining == REM_W'(1);

  assign set_rd_done = (last_word && dir_q) || (zero_len && mode_dir);
  assign set_wr_done = (last_word && !dir_q) || (zero_len && !mode_dir);
  assign set_rd_err  = misalign_hit && mode_dir;
  assign set_wr_err  = misalign_hit && !mode_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dir_q     <= 1'b0;
      inc_q     <= 1'b0;
      cur_addr  <= '0;
      remaining <= '0;
    end else if (launch) begin
      busy      <= 1'b1;
      dir_q     <= mode_dir;
      inc_q     <= mode_inc;
      cur_addr  <= start_addr;
      remaining <= len_words;
    end else if (word_xfer) begin
      remaining <= remaining - REM_W'(1);
      if (inc_q) cur_addr <= cur_addr + AW'(WORD_BYTES);
      if (last_word) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sdh_dma_ctrl.sv
module sdh_dma_ctrl
  import sdh_dma_pkg::*;
#(
  parameter int AW          = 64,
  parameter int CNT_W       = 8,
  parameter int BSZ_W       = 12,
  parameter int WORD_BYTES  = 4,
  parameter int ALIGN_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          pio_sel,
  output logic          mem_req_vld,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rdy,
  input  logic [31:0]   mem_rdata,
  input  logic [31:0]   card_din,
  input  logic          card_din_vld,
  output logic          card_din_pop,
  output logic [31:0]   card_dout,
  output logic          card_dout_vld,
  input  logic          card_dout_rdy
);
  logic             busy, dir_q, inc_q, mode_dir, mode_inc, dma_en;
  logic             start_req, start_accept, misalign_hit, word_xfer, last_word;
  logic             set_rd_done, set_wr_done, set_rd_err, set_wr_err;
  logic [AW-1:0]    start_addr, cur_addr;
  logic [CNT_W-1:0] blk_cnt;
  logic [BSZ_W-1:0] blk_size;

  assign start_req = reg_wr && reg_sel == SEL_CTRL && reg_wdata[BIT_START];

  sdh_dma_regs #(.AW(AW), .CNT_W(CNT_W), .BSZ_W(BSZ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .set_rd_done(set_rd_done), .set_wr_done(set_wr_done),
    .set_rd_err(set_rd_err), .set_wr_err(set_wr_err),
    .mode_dir(mode_dir), .mode_inc(mode_inc), .dma_en(dma_en),
    .start_addr(start_addr), .blk_cnt(blk_cnt), .blk_size(blk_size),
    .rdata(reg_rdata)
  );

  sdh_dma_engine #(.AW(AW), .CNT_W(CNT_W), .BSZ_W(BSZ_W),
                   .WORD_BYTES(WORD_BYTES), .ALIGN_BYTES(ALIGN_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .dma_en(dma_en),
    .mode_dir(mode_dir), .mode_inc(mode_inc), .start_addr(start_addr),
    .blk_cnt(blk_cnt), .blk_size(blk_size),
    .card_din_vld(card_din_vld), .card_dout_rdy(card_dout_rdy), .mem_rdy(mem_rdy),
    .busy(busy), .dir_q(dir_q), .inc_q(inc_q), .cur_addr(cur_addr),
    .req_vld(mem_req_vld), .start_accept(start_accept), .misalign_hit(misalign_hit),
    .word_xfer(word_xfer), .last_word(last_word),
    .set_rd_done(set_rd_done), .set_wr_done(set_wr_done),
    .set_rd_err(set_rd_err), .set_wr_err(set_wr_err)
  );

  assign pio_sel       = !dma_en;
  assign mem_we        = dir_q;
  assign mem_addr      = cur_addr;
  assign mem_wdata     = card_din;
  assign card_din_pop  = word_xfer && dir_q;
  assign card_dout     = mem_rdata;
  assign card_dout_vld = word_xfer && !dir_q;
endmodule

// File: rtl/sdh_dma_chk.sv
module sdh_dma_chk #(
  parameter int AW = 64,
  parameter int WB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          inc_q,
  input logic          mem_req_vld,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] start_addr,
  input logic          word_xfer,
  input logic          last_word,
  input logic          misalign_hit,
  input logic          start_accept,
  input logic [3:0]    reg_sel,
  input logic [31:0]   reg_rdata
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_vld); // R4
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !busy); // R4
  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !inc_q && $past(busy) |-> $stable(mem_addr)); // R7
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_xfer && inc_q && !last_word |=> mem_addr == $past(mem_addr) + AW'(WB)); // R5
  AST_MISALIGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_hit |=> !busy); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(start_addr)); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_accept); // R11
  AST_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 4'd1 |-> reg_rdata == 32'd0); // R3
endmodule

bind sdh_dma_ctrl sdh_dma_chk #(.AW(AW), .WB(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .inc_q(inc_q), .mem_req_vld(mem_req_vld),
  .mem_addr(mem_addr), .start_addr(start_addr), .word_xfer(word_xfer),
  .last_word(last_word), .misalign_hit(misalign_hit), .start_accept(start_accept),
  .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/sim_sdh_dma_ctrl.sv
`timescale 1ns/1ps
module sim_sdh_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_sel = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        pio_sel, mem_req_vld, mem_we, card_din_pop, card_dout_vld;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, card_dout, mem_rdata, card_din;
  logic        mem_rdy = 1'b0;
  logic        card_dout_rdy = 1'b0;
  logic        card_din_vld = 1'b1;

  int checks = 0, fails = 0, cyc = 0, tick = 0;
  int obs_n = 0, bad = 0, card_idx = 0;
  bit pend_pop = 0, hold = 0, run_dir = 0, run_inc = 0;
  logic [63:0] run_base = '0;

  always #10 clk = ~clk;

  sdh_dma_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pio_sel(pio_sel), .mem_req_vld(mem_req_vld), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .card_din(card_din), .card_din_vld(card_din_vld), .card_din_pop(card_din_pop),
    .card_dout(card_dout), .card_dout_vld(card_dout_vld), .card_dout_rdy(card_dout_rdy)
  );

  assign mem_rdata = mem_addr[31:0] ^ 32'h5A5A_5A5A;
  assign card_din  = 32'hC0DE_0000 + 32'(card_idx);

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  // drive handshakes, settle, then record the beat the next rising edge commits
  always @(negedge clk) begin
    logic [63:0] ea;
    if (pend_pop) card_idx++;
    tick++;
    mem_rdy       = !hold && (tick % 3 != 1);
    card_dout_rdy = (tick % 4 != 2);
    #1;
    pend_pop = 0;
    if (mem_req_vld && mem_rdy) begin
      ea = run_base + (run_inc ? 64'(obs_n) * 64'd4 : 64'd0);
      if (mem_addr != ea) bad++;
      if (mem_we != run_dir) bad++;
      if (run_dir) begin
        if (mem_wdata != 32'hC0DE_0000 + 32'(card_idx) || !card_din_pop) bad++;
        pend_pop = 1;
      end else if (!card_dout_vld || card_dout != (ea[31:0] ^ 32'h5A5A_5A5A)) bad++;
      obs_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] v);
    @(negedge clk); reg_wr = 1'b0; reg_sel = s; #3; v = reg_rdata;
  endtask

  task automatic launch(input int c, input int s, input bit d, input bit inc, input logic [63:0] base);
    wr(4'd4, base[31:0]); wr(4'd5, base[63:32]);
    wr(4'd0, (32'(d) << 16) | 32'(inc));
    wr(4'd7, 32'(c)); wr(4'd8, 32'(s));
    wr(4'd2, 32'd0); wr(4'd3, 32'd0);
    @(negedge clk); #3;
    obs_n = 0; bad = 0; card_idx = 0;
    run_dir = d; run_inc = inc; run_base = base;
    wr(4'd1, 32'd1);
  endtask

  task automatic wait_status(output logic [31:0] v);
    v = 0;
    for (int k = 0; k < 200 && v == 0; k++) begin
      logic [31:0] e;
      rd(4'd2, v); rd(4'd3, e);
      v = v | e;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] base;
    int expw;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 9; r++) begin
      rd(4'(r), v);
      chk(v == 0, "R1 reg reset", 64'(v), 0);
    end
    chk(pio_sel == 1 && mem_req_vld == 0, "R1 outputs", {pio_sel, mem_req_vld}, 2'b10);
    rst_n = 1'b1;
    rd(4'd2, v);
    chk(v == 0, "R1 done after release", 64'(v), 0);

    // R3 start with DMA disabled
    wr(4'd7, 32'd2); wr(4'd8, 32'd8);
    @(negedge clk); #3; obs_n = 0;
    wr(4'd1, 32'd1);
    repeat (10) @(negedge clk);
    rd(4'd2, v);
    chk(v == 0 && obs_n == 0, "R3 start ignored when disabled", {v, 32'(obs_n)}, 0);

    // R2 readback
    wr(4'd6, 32'h0000_0002);
    chk(pio_sel == 0, "R2 pio_sel low when enabled", 64'(pio_sel), 0);
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v);
    chk(v == 32'h0001_0001, "R2 mode readback", 64'(v), 64'h0001_0001);
    wr(4'd5, 32'h0000_0012); rd(4'd5, v);
    chk(v == 32'h12, "R2 addr hi readback", 64'(v), 64'h12);
    wr(4'd8, 32'd200); rd(4'd8, v);
    chk(v == 32'd200, "R2 size readback", 64'(v), 200);

    // sweep: count x size x direction x step
    for (int c = 0; c < 4; c++)
      for (int si = 0; si < 3; si++)
        for (int d = 0; d < 2; d++)
          for (int inc = 0; inc < 2; inc++) begin
            int s;
            s = (si == 0) ? 4 : (si == 1) ? 6 : 12;
            base = 64'h0000_0012_3456_7000 + 64'((c * 12 + si * 4 + d * 2 + inc) * 256);
            expw = (c * s) / 4;
            launch(c, s, d[0], inc[0], base);
            rd(4'd1, v);
            chk(v == 0, "R3 start bit self-clears", 64'(v), 0);
            wait_status(v);
            chk(obs_n == expw, "R4 word count", 64'(obs_n), 64'(expw));
            chk(bad == 0, d ? "R5 R7 card-to-memory beats" : "R6 R7 memory-to-card beats", 64'(bad), 0);
            chk(v == (d ? 32'h0010_0000 : 32'h0001_0000),
                c == 0 ? "R12 zero-length done" : (d ? "R5 done bit 20" : "R6 done bit 16"),
                64'(v), d ? 64'h0010_0000 : 64'h0001_0000);
          end

    // R8 misaligned start, both directions
    for (int d = 0; d < 2; d++) begin
      launch(2, 8, d[0], 1'b1, 64'h0000_0012_3456_7808);
      repeat (10) @(negedge clk);
      rd(4'd3, v);
      chk(v == (d ? 32'h0002_0000 : 32'h0001_0000), "R8 error bit", 64'(v),
          d ? 64'h0002_0000 : 64'h0001_0000);
      rd(4'd2, v);
      chk(v == 0 && obs_n == 0, "R8 no data no done", {v, 32'(obs_n)}, 0);
    end

    // R9 partial clear
    launch(0, 4, 1'b1, 1'b1, 64'h100);
    launch(0, 4, 1'b0, 1'b1, 64'h100);
    wr(4'd2, 32'h0010_0000); // clearing before the second start already reset bit 20
    launch(0, 4, 1'b1, 1'b1, 64'h100);
    @(negedge clk);
    rd(4'd2, v);
    chk(v == 32'h0010_0000, "R9 done set again", 64'(v), 64'h0010_0000);
    wr(4'd2, 32'h0001_0000); rd(4'd2, v);
    chk(v == 0, "R9 bit written 0 clears", 64'(v), 0);

    // R10 and R11 while busy
    hold = 1;
    launch(2, 8, 1'b1, 1'b1, 64'h0000_0012_3456_9000);
    wr(4'd4, 32'hFFFF_0000);
    rd(4'd4, v);
    chk(v == 32'h3456_9000, "R10 addr write ignored while busy", 64'(v), 64'h3456_9000);
    wr(4'd7, 32'd5);
    wr(4'd1, 32'd1);
    hold = 0;
    wait_status(v);
    repeat (20) @(negedge clk);
    chk(obs_n == 4 && bad == 0, "R11 second start ignored", 64'(obs_n), 4);
    wr(4'd4, 32'hABCD_0010); rd(4'd4, v);
    chk(v == 32'hABCD_0010, "R10 addr write when idle", 64'(v), 64'hABCD_0010);
    summary();
  end
endmodule